// File: doc/BRIEF.md
# Dual-Purpose Bank Select Controller

This controller sits between a processor's write path and a banked cartridge memory. It decides which switchable ROM bank and which external RAM bank the rest of the system addresses. Writes into the ROM address window are decoded on address bits 14:13 into four control regions. One of these regions holds a 2-bit select register. A mode bit decides how that register is used. With the mode bit clear, the register supplies the two bits above a 6-bit ROM bank field and the RAM bank stays at 0. With the mode bit set, the register chooses the RAM bank and the ROM bank is the 6-bit field alone.

RAM reads are always permitted. The enable register gates only RAM writes. The selected ROM bank is never moved off bank 0. It is masked to the number of banks fitted. All outputs are registered state and change on the clock edge that samples a write strobe.

Top module: `alt_bank_ctrl`

## Requirements
- R1: After reset, romBank is 1, ramBank is 0, ramWriteEn is 0, and the mode bit is clear.
- R2: A write to region 0 (addr[14:13] = 0) sets ramWriteEn when data[3:0] equals 4'hA. Any other low nibble clears it, and data[7:4] is ignored.
- R3: ramReadEn is 1 in every cycle, whatever the state of the write enable.
- R4: A write to region 1 (addr[14:13] = 1) stores data[5:0] as the ROM bank field. data[7:6] is ignored.
- R5: A write to region 2 (addr[14:13] = 2) stores data[1:0] in the 2-bit select register. data[7:2] is ignored.
- R6: With the mode bit clear, romBank is {select, field} and ramBank is 0.
- R7: With the mode bit set, romBank is the 6-bit field with its upper bits zero, and ramBank is the select register.
- R8: A write to region 3 (addr[14:13] = 3) sets the mode bit from data[0], ignoring data[7:1]. Both romBank and ramBank follow the new mode at once.
- R9: A ROM bank value of 0 is presented as 0; there is no substitution of bank 1.
- R10: romBank is masked by ROM_BANK_COUNT-1 (default 128 banks, so bit 7 is dropped), and ramBank is masked by RAM_BANK_COUNT-1.
- R11: Outputs change only on the rising clock edge that samples wrStrobe high. They reflect that write from the next cycle on, and they hold when wrStrobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | One-cycle write request into the control regions |
| addr | input | 16 | Write address; bits 14:13 pick the region |
| data | input | 8 | Write data |
| romBank | output | 8 | Switchable ROM bank number |
| ramBank | output | 2 | External RAM bank number |
| ramReadEn | output | 1 | RAM read permitted (always 1) |
| ramWriteEn | output | 1 | RAM write permitted |

## Verification
The bound checker watches several properties on every cycle. RAM reads stay enabled. The outputs hold in any cycle without a strobe. The RAM bank is 0 whenever the mode bit is clear. In select mode the ROM bank's upper bits are zero. Each region write lands in its own register with only the listed data bits. The bench is needed for the whole bank arithmetic: the concatenation of select and field, the mask that drops bank bits, and bank 0 passing through unchanged. The bench is also needed for the mode switch that remaps both outputs in one step. These are checked against a behavioural model on every clock and at directed points.

// File: rtl/bank_ctrl_pkg.sv
package bank_ctrl_pkg;
  // One-hot region strobes handed from decode to the register datapath
  typedef struct packed {
    logic setWe;
    logic setField;
    logic setSel;
    logic setMode;
  } bankStrobes_t;
endpackage

// File: rtl/bank_ctrl_decode.sv
module bank_ctrl_decode
  import bank_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REGION_LSB = 13
) (
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobes_t      strobes
);
  localparam int REGIONS = 4;

  logic [1:0]         region;
  logic [REGIONS-1:0] hit;

  assign region = addr[REGION_LSB +: 2];

  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    assign hit[g] = wrStrobe && (region == 2'(g));
  end

  always_comb begin
    strobes.setWe    = hit[0];
    strobes.setField = hit[1];
    strobes.setSel   = hit[2];
    strobes.setMode  = hit[3];
  end
endmodule

// File: rtl/bank_ctrl_regs.sv
module bank_ctrl_regs
  import bank_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FIELD_W = 6,
  parameter int SEL_W = 2,
  parameter int ROM_BANK_COUNT = 128,
  parameter int RAM_BANK_COUNT = 4,
  parameter logic [3:0] WE_KEY = 4'hA
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bankStrobes_t             strobes,
  input  logic [DATA_W-1:0]        data,
  output logic [FIELD_W+SEL_W-1:0] romBank,
  output logic [SEL_W-1:0]         ramBank,
  output logic                     ramWriteEn,
  output logic                     modeQ,
  output logic [FIELD_W-1:0]       fieldQ,
  output logic [SEL_W-1:0]         selQ
);
  localparam int RAW_W = FIELD_W + SEL_W;
  localparam logic [RAW_W-1:0] ROM_MASK = RAW_W'(ROM_BANK_COUNT - 1);
  localparam logic [SEL_W-1:0] RAM_MASK = SEL_W'(RAM_BANK_COUNT - 1);

  logic             weQ;
  logic [RAW_W-1:0] rawRom;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ    <= 1'b0;
      fieldQ <= FIELD_W'(1);
      selQ   <= '0;
      modeQ  <= 1'b0;
    end else begin
      if (strobes.setWe)    weQ    <= (data[3:0] == WE_KEY);
      if (strobes.setField) fieldQ <= data[FIELD_W-1:0];
      if (strobes.setSel)   selQ   <= data[SEL_W-1:0];
      if (strobes.setMode)  modeQ  <= data[0];
    end
  end

  // Select register feeds either the high ROM bits or the RAM bank
  always_comb begin
    if (modeQ) begin
      rawRom  = {{SEL_W{1'b0}}, fieldQ};
      ramBank = selQ & RAM_MASK;
    end else begin
      rawRom  = {selQ, fieldQ};
      ramBank = '0;
    end
    romBank    = rawRom & ROM_MASK;
    ramWriteEn = weQ;
  end
endmodule

// File: rtl/alt_bank_ctrl.sv
module alt_bank_ctrl
  import bank_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FIELD_W = 6,
  parameter int SEL_W = 2,
  parameter int ROM_BANK_COUNT = 128,
  parameter int RAM_BANK_COUNT = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrStrobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        data,
  output logic [FIELD_W+SEL_W-1:0] romBank,
  output logic [SEL_W-1:0]         ramBank,
  output logic                     ramReadEn,
  output logic                     ramWriteEn
);
  bankStrobes_t       strobes;
  logic               modeQ;
  logic [FIELD_W-1:0] fieldQ;
  logic [SEL_W-1:0]   selQ;

  bank_ctrl_decode #(.ADDR_W(ADDR_W), .REGION_LSB(13)) u_decode (
    .wrStrobe(wrStrobe), .addr(addr), .strobes(strobes)
  );

  bank_ctrl_regs #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W),
    .ROM_BANK_COUNT(ROM_BANK_COUNT), .RAM_BANK_COUNT(RAM_BANK_COUNT),
    .WE_KEY(4'hA)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .data(data),
    .romBank(romBank), .ramBank(ramBank), .ramWriteEn(ramWriteEn),
    .modeQ(modeQ), .fieldQ(fieldQ), .selQ(selQ)
  );

  assign ramReadEn = 1'b1;
endmodule

// File: rtl/bank_ctrl_checker.sv
module bank_ctrl_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FIELD_W = 6,
  parameter int SEL_W = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrStrobe,
  input logic [ADDR_W-1:0]        addr,
  input logic [DATA_W-1:0]        data,
  input logic [FIELD_W+SEL_W-1:0] romBank,
  input logic [SEL_W-1:0]         ramBank,
  input logic                     ramReadEn,
  input logic                     ramWriteEn,
  input logic                     modeQ,
  input logic [FIELD_W-1:0]       fieldQ,
  input logic [SEL_W-1:0]         selQ
);
  logic [1:0] region;
  assign region = addr[14:13];

  a_r3_read_always: assert property (@(posedge clk) disable iff (!rstN)
    ramReadEn);

  a_r2_write_key: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && region == 2'd0) |=> (ramWriteEn == ($past(data[3:0]) == 4'hA)));

  a_r4_field_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && region == 2'd1) |=> (fieldQ == $past(data[FIELD_W-1:0])));

  a_r5_sel_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && region == 2'd2) |=> (selQ == $past(data[SEL_W-1:0])));

  a_r8_mode_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && region == 2'd3) |=> (modeQ == $past(data[0])));

  a_r6_ram_zero: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ |-> (ramBank == '0));

  a_r7_rom_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> (romBank[FIELD_W+SEL_W-1:FIELD_W] == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrStrobe) |-> ($stable(romBank) && $stable(ramBank) && $stable(ramWriteEn)));
endmodule

bind alt_bank_ctrl bank_ctrl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .SEL_W(SEL_W)
) u_checker (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .addr(addr), .data(data),
  .romBank(romBank), .ramBank(ramBank), .ramReadEn(ramReadEn),
  .ramWriteEn(ramWriteEn), .modeQ(modeQ), .fieldQ(fieldQ), .selQ(selQ)
);

// File: tb/test_alt_bank_ctrl.sv
`timescale 1ns/1ps
module test_alt_bank_ctrl;
  localparam int ROM_BANKS = 128;
  localparam int RAM_BANKS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [7:0]  romBank;
  logic [1:0]  ramBank;
  logic        ramReadEn;
  logic        ramWriteEn;

  int checkCnt = 0;
  int failCnt = 0;
  bit modelOn = 1'b0;

  // behavioural reference state
  int mWe, mField, mSel, mMode;

  always #2.5 clk = ~clk;

  alt_bank_ctrl i_alt_bank_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .addr(addr), .data(data),
    .romBank(romBank), .ramBank(ramBank), .ramReadEn(ramReadEn),
    .ramWriteEn(ramWriteEn)
  );

  function automatic int expRom();
    int v;
    if (mMode != 0) v = mField;
    else v = mSel * 64 + mField;
    return v % ROM_BANKS;
  endfunction

  function automatic int expRam();
    if (mMode != 0) return mSel % RAM_BANKS;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mWe <= 0; mField <= 1; mSel <= 0; mMode <= 0;
    end else if (wrStrobe) begin
      case ((addr >> 13) % 4)
        0: mWe <= ((data % 16) == 10) ? 1 : 0;
        1: mField <= data % 64;
        2: mSel <= data % 4;
        default: mMode <= data % 2;
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model (R11 timing, R6/R7 mapping)
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      chk("R11 model romBank", int'(romBank), expRom());
      chk("R11 model ramBank", int'(ramBank), expRam());
      chk("R11 model ramWriteEn", int'(ramWriteEn), mWe);
      chk("R3 model ramReadEn", int'(ramReadEn), 1);
    end
  end

  task automatic doWrite(int region, int value);
    @(negedge clk);
    wrStrobe = 1'b1;
    addr = 16'(region * 16'h2000 + 16'h0ABC);
    data = 8'(value);
    @(negedge clk);
    wrStrobe = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 reset romBank", int'(romBank), 1);
    chk("R1 reset ramBank", int'(ramBank), 0);
    chk("R1 reset ramWriteEn", int'(ramWriteEn), 0);
    chk("R3 reset ramReadEn", int'(ramReadEn), 1);
    modelOn = 1'b1;

    doWrite(0, 8'h0A); chk("R2 key enables", int'(ramWriteEn), 1);
    doWrite(0, 8'h1B); chk("R2 wrong nibble clears", int'(ramWriteEn), 0);
    doWrite(0, 8'hFA); chk("R2 high nibble ignored", int'(ramWriteEn), 1);
    chk("R3 read with writes on", int'(ramReadEn), 1);

    doWrite(1, 8'hFF); chk("R4 field low bits only", int'(romBank), 63);
    doWrite(2, 8'hFD); chk("R5 sel low bits only", int'(romBank), 127);
    chk("R6 ram zero in rom mode", int'(ramBank), 0);

    doWrite(1, 8'h00); chk("R6 concat sel above field", int'(romBank), 64);
    doWrite(2, 8'h00); chk("R9 bank zero kept", int'(romBank), 0);

    doWrite(2, 8'h03);
    doWrite(1, 8'h05); chk("R10 mask drops bit 7", int'(romBank), 69);
    doWrite(3, 8'h01);
    chk("R7 rom is field", int'(romBank), 5);
    chk("R8 ram follows sel", int'(ramBank), 3);
    doWrite(3, 8'hFE);
    chk("R8 mode bit0 only rom", int'(romBank), 69);
    chk("R8 mode bit0 only ram", int'(ramBank), 0);

    // data present without strobe must not change anything (R11)
    @(negedge clk);
    addr = 16'h2000; data = 8'h11;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 no strobe rom hold", int'(romBank), 69);
    chk("R11 no strobe we hold", int'(ramWriteEn), 1);

    // output changes only after the sampling edge (R11)
    @(negedge clk);
    wrStrobe = 1'b1; addr = 16'h2000; data = 8'h21;
    #1;
    chk("R11 before edge", int'(romBank), 69);
    @(negedge clk);
    wrStrobe = 1'b0;
    #1;
    chk("R11 after edge", int'(romBank), 97);

    repeat (2) @(negedge clk);
    modelOn = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule